// File: doc/BRIEF.md
# Companion Chip Register and GPIO Block

This block is a memory-mapped helper peripheral. It holds a small set of 16-bit control registers and drives a 16-line general-purpose I/O port. A host reaches it over a plain synchronous register bus with an address, a write strobe, a read strobe, write data and read data. Writes are cut down to 16 bits before they are stored. Read data comes from a register and is valid one cycle after the read request.

The GPIO side keeps a direction register and a level register. The driven output pattern is the level register masked by the direction register. It is recomputed only when software writes the direction or the level register. When that happens, each line whose driven value toggled gets a one-cycle change strobe. External input lines update their bit of the level register when they change. That update alone does not move the driven outputs.

Top module: `companion_io_top`

## Requirements
- R1: After reset the status register (offset 0x08) reads 0x0002. Every other register reads 0x0000, and `gpioOut` and `gpioChg` are all zero.
- R2: A write stores only bits 15:0 of `busWdata`. The plain storage registers sit at 0x00 (mode), 0x04 (divider), 0x10 (clock control), 0x14 (interrupt request), 0x18 (interrupt mask) and 0x1C (interrupt status). Each reads back what was stored.
- R3: A write to the power register (0x0C) whose bit 7 is set stores the 16-bit value ORed with 0x8040. With bit 7 clear, the 16-bit value is stored unchanged.
- R4: Writes to the status register or to any unmapped offset change nothing. A read of an unmapped offset returns 0. Unmapped means any offset that is not a multiple of 4, or any offset above 0x28.
- R5: A write to 0x24 or to 0x28 stores (data AND direction) into the level register. Reads of 0x24 and of 0x28 both return the level register, and a read of 0x20 returns the direction register.
- R6: After a write to direction (0x20) or to level (0x24/0x28), `gpioOut` equals level AND direction, visible in the cycle after the write. No other event changes `gpioOut`.
- R7: `gpioChg` bit i is high for exactly the one cycle after a write in which `gpioOut` bit i toggled, and is low otherwise.
- R8: When an external input `gpioIn[i]` changes, level bit i takes the new input value at the next clock edge. `gpioOut` stays unchanged until the next direction or level write.
- R9: When a level write and an input change land in the same cycle, the written value is stored and that input change is dropped.
- R10: Read data is registered: `busRdata` shows the addressed register one cycle after `busRead` and holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte offset of the register access |
| busWrite | input | 1 | Write request for this cycle |
| busRead | input | 1 | Read request for this cycle |
| busWdata | input | 32 | Write data; only bits 15:0 are kept |
| busRdata | output | 16 | Registered read data |
| gpioIn | input | 16 | External GPIO input lines |
| gpioOut | output | 16 | Driven GPIO levels (level AND direction) |
| gpioChg | output | 16 | One-cycle strobes on lines whose driven value toggled |

## Verification
Two functions can meet in one cycle: a software write to the level register, and a change on an external input line. Both try to update the same level register. The bench arranges the collision by raising a level write and flipping an input in the same cycle. It then reads the level back and checks that the written value stands and the input edge is lost. A later write confirms that the driven outputs follow the stored value.

// File: rtl/cio_pkg.sv
package cio_pkg;

  // Plain storage registers, indexed inside the register file
  localparam int N_PLAIN  = 6;
  localparam int PL_IDX_W = 3;
  localparam int PL_MODE  = 0;
  localparam int PL_DIV   = 1;
  localparam int PL_CLK   = 2;
  localparam int PL_IRQ   = 3;
  localparam int PL_MASK  = 4;
  localparam int PL_ISTAT = 5;

  // Byte offsets decoded by the control module
  localparam logic [7:0] OFF_MODE  = 8'h00;
  localparam logic [7:0] OFF_DIV   = 8'h04;
  localparam logic [7:0] OFF_STAT  = 8'h08;
  localparam logic [7:0] OFF_PWR   = 8'h0C;
  localparam logic [7:0] OFF_CLK   = 8'h10;
  localparam logic [7:0] OFF_IRQ   = 8'h14;
  localparam logic [7:0] OFF_MASK  = 8'h18;
  localparam logic [7:0] OFF_ISTAT = 8'h1C;
  localparam logic [7:0] OFF_DIR   = 8'h20;
  localparam logic [7:0] OFF_LVLW  = 8'h24;
  localparam logic [7:0] OFF_LVLR  = 8'h28;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_PLAIN,
    RD_STAT,
    RD_PWR,
    RD_DIR,
    RD_LVL
  } rdSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [N_PLAIN-1:0]  wrPlain;
    logic                wrPwr;
    logic                wrDir;
    logic                wrLvl;
    logic                inUpdEn;
    logic                rdEn;
    rdSel_e              rdSel;
    logic [PL_IDX_W-1:0] rdIdx;
  } ctlStrobe_t;

endpackage

// File: rtl/cio_ctrl.sv
module cio_ctrl
  import cio_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  output ctlStrobe_t        ctl
);

  always_comb begin
    ctl         = '0;
    ctl.rdSel   = RD_ZERO;
    ctl.rdEn    = busRead;
    case (busAddr)
      ADDR_W'(OFF_MODE): begin
        ctl.wrPlain[PL_MODE] = busWrite;
        ctl.rdSel = RD_PLAIN;
        ctl.rdIdx = PL_IDX_W'(PL_MODE);
      end
      ADDR_W'(OFF_DIV): begin
        ctl.wrPlain[PL_DIV] = busWrite;
        ctl.rdSel = RD_PLAIN;
        ctl.rdIdx = PL_IDX_W'(PL_DIV);
      end
      ADDR_W'(OFF_STAT): begin
        // read-only: writes are dropped here
        ctl.rdSel = RD_STAT;
      end
      ADDR_W'(OFF_PWR): begin
        ctl.wrPwr = busWrite;
        ctl.rdSel = RD_PWR;
      end
      ADDR_W'(OFF_CLK): begin
        ctl.wrPlain[PL_CLK] = busWrite;
        ctl.rdSel = RD_PLAIN;
        ctl.rdIdx = PL_IDX_W'(PL_CLK);
      end
      ADDR_W'(OFF_IRQ): begin
        ctl.wrPlain[PL_IRQ] = busWrite;
        ctl.rdSel = RD_PLAIN;
        ctl.rdIdx = PL_IDX_W'(PL_IRQ);
      end
      ADDR_W'(OFF_MASK): begin
        ctl.wrPlain[PL_MASK] = busWrite;
        ctl.rdSel = RD_PLAIN;
        ctl.rdIdx = PL_IDX_W'(PL_MASK);
      end
      ADDR_W'(OFF_ISTAT): begin
        ctl.wrPlain[PL_ISTAT] = busWrite;
        ctl.rdSel = RD_PLAIN;
        ctl.rdIdx = PL_IDX_W'(PL_ISTAT);
      end
      ADDR_W'(OFF_DIR): begin
        ctl.wrDir = busWrite;
        ctl.rdSel = RD_DIR;
      end
      ADDR_W'(OFF_LVLW), ADDR_W'(OFF_LVLR): begin
        ctl.wrLvl = busWrite;
        ctl.rdSel = RD_LVL;
      end
      default: begin
        ctl.rdSel = RD_ZERO;
      end
    endcase
    // a level write takes priority over input edges in the same cycle
    ctl.inUpdEn = !ctl.wrLvl;
  end

endmodule

// File: rtl/cio_regfile.sv
module cio_regfile
  import cio_pkg::*;
#(
  parameter int                DATA_W       = 16,
  parameter logic [DATA_W-1:0] STAT_RST     = 'h2,
  parameter int                PWR_TRIG_BIT = 7,
  parameter logic [DATA_W-1:0] PWR_FORCE    = 'h8040
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] dirQ,
  input  logic [DATA_W-1:0] lvlQ,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] plainQ [N_PLAIN];
  logic [DATA_W-1:0] pwrQ;
  logic [DATA_W-1:0] pwrNext;
  logic [DATA_W-1:0] plainSel;
  logic [DATA_W-1:0] rdNext;

  for (genvar g = 0; g < N_PLAIN; g++) begin : gPlain
    always_ff @(posedge clk) begin
      if (!rstN) begin
        plainQ[g] <= '0;
      end else if (ctl.wrPlain[g]) begin
        plainQ[g] <= wdata;
      end
    end
  end

  assign pwrNext = wdata[PWR_TRIG_BIT] ? (wdata | PWR_FORCE) : wdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwrQ <= '0;
    end else if (ctl.wrPwr) begin
      pwrQ <= pwrNext;
    end
  end

  always_comb begin
    plainSel = '0;
    for (int k = 0; k < N_PLAIN; k++) begin
      if (ctl.rdIdx == PL_IDX_W'(k)) begin
        plainSel = plainQ[k];
      end
    end
  end

  always_comb begin
    case (ctl.rdSel)
      RD_PLAIN: rdNext = plainSel;
      RD_STAT:  rdNext = STAT_RST;
      RD_PWR:   rdNext = pwrQ;
      RD_DIR:   rdNext = dirQ;
      RD_LVL:   rdNext = lvlQ;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (ctl.rdEn) begin
      rdata <= rdNext;
    end
  end

endmodule

// File: rtl/cio_port.sv
module cio_port
  import cio_pkg::*;
#(
  parameter int N_GPIO = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [N_GPIO-1:0] wdata,
  input  logic [N_GPIO-1:0] gpioIn,
  output logic [N_GPIO-1:0] dirQ,
  output logic [N_GPIO-1:0] lvlQ,
  output logic [N_GPIO-1:0] gpioOut,
  output logic [N_GPIO-1:0] gpioChg
);

  logic [N_GPIO-1:0] inQ;
  logic [N_GPIO-1:0] drvNext;
  logic              drvUpd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ <= '0;
    end else if (ctl.wrDir) begin
      dirQ <= wdata;
    end
  end

  // per-line level bit: bus write first, then input edge
  for (genvar i = 0; i < N_GPIO; i++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rstN) begin
        inQ[i]  <= 1'b0;
        lvlQ[i] <= 1'b0;
      end else begin
        inQ[i] <= gpioIn[i];
        if (ctl.wrLvl) begin
          lvlQ[i] <= wdata[i] & dirQ[i];
        end else if (ctl.inUpdEn && (gpioIn[i] != inQ[i])) begin
          lvlQ[i] <= gpioIn[i];
        end
      end
    end
  end

  assign drvUpd = ctl.wrDir | ctl.wrLvl;

  always_comb begin
    if (ctl.wrDir) begin
      drvNext = lvlQ & wdata;
    end else if (ctl.wrLvl) begin
      drvNext = wdata & dirQ;
    end else begin
      drvNext = gpioOut;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gpioOut <= '0;
      gpioChg <= '0;
    end else begin
      gpioOut <= drvNext;
      gpioChg <= drvUpd ? (drvNext ^ gpioOut) : '0;
    end
  end

endmodule

// File: rtl/companion_io_top.sv
module companion_io_top
  import cio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] gpioIn,
  output logic [DATA_W-1:0] gpioOut,
  output logic [DATA_W-1:0] gpioChg
);

  ctlStrobe_t        ctl;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] dirQ;
  logic [DATA_W-1:0] lvlQ;
  logic              unusedWdataHi;

  // only the low half-word of the bus is kept
  assign wdata         = busWdata[DATA_W-1:0];
  assign unusedWdataHi = ^busWdata[BUS_W-1:DATA_W];

  cio_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr (busAddr),
    .busWrite(busWrite),
    .busRead (busRead),
    .ctl     (ctl)
  );

  cio_regfile #(.DATA_W(DATA_W)) uRegs (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctl),
    .wdata(wdata),
    .dirQ (dirQ),
    .lvlQ (lvlQ),
    .rdata(busRdata)
  );

  cio_port #(.N_GPIO(DATA_W)) uPort (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .wdata  (wdata),
    .gpioIn (gpioIn),
    .dirQ   (dirQ),
    .lvlQ   (lvlQ),
    .gpioOut(gpioOut),
    .gpioChg(gpioChg)
  );

endmodule

// File: rtl/companion_io_chk.sv
module companion_io_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrite,
  input logic              busRead,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [DATA_W-1:0] gpioOut,
  input logic [DATA_W-1:0] gpioChg
);

  logic [DATA_W-1:0] dirModel;
  logic              dirWr;
  logic              gpioWr;
  logic              mapped;

  assign dirWr  = busWrite && (busAddr == ADDR_W'(8'h20));
  assign gpioWr = dirWr || (busWrite && ((busAddr == ADDR_W'(8'h24)) ||
                                         (busAddr == ADDR_W'(8'h28))));
  assign mapped = (busAddr[1:0] == 2'b00) && (busAddr <= ADDR_W'(8'h28));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirModel <= '0;
    end else if (dirWr) begin
      dirModel <= busWdata;
    end
  end

  // R6
  out_within_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gpioOut & ~dirModel) == '0);

  // R6
  out_only_on_gpio_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(gpioWr) |-> $stable(gpioOut));

  // R7
  chg_matches_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    gpioChg == (gpioOut ^ $past(gpioOut)));

  // R4
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && !mapped) |=> (busRdata == '0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busRead) |-> $stable(busRdata));

endmodule

bind companion_io_top companion_io_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busWrite(busWrite),
  .busRead (busRead),
  .busWdata(busWdata[DATA_W-1:0]),
  .busRdata(busRdata),
  .gpioOut (gpioOut),
  .gpioChg (gpioChg)
);

// File: tb/tb_companion_io_top.sv
`timescale 1ns/1ps
module tb_companion_io_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic        busRead = 1'b0;
  logic [31:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [15:0] gpioIn = '0;
  logic [15:0] gpioOut;
  logic [15:0] gpioChg;

  int checks = 0;
  int errors = 0;

  // independent model of the GPIO state
  logic [15:0] mDir = '0, mLvl = '0, mOut = '0, mChg = '0, mIn = '0;

  always #10 clk = ~clk;

  companion_io_top dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busRead(busRead), .busWdata(busWdata), .busRdata(busRdata),
    .gpioIn(gpioIn), .gpioOut(gpioOut), .gpioChg(gpioChg)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [7:0] a, input logic [31:0] d);
    logic [15:0] w;
    logic [15:0] nOut;
    w = d[15:0];
    mChg = '0;
    if (a == 8'h20) begin
      mDir = w;
      nOut = mLvl & mDir;
      mChg = nOut ^ mOut;
      mOut = nOut;
    end else if (a == 8'h24 || a == 8'h28) begin
      mLvl = w & mDir;
      nOut = mLvl;
      mChg = nOut ^ mOut;
      mOut = nOut;
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic busRd(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk);
    busAddr = a; busRead = 1'b1;
    @(negedge clk);
    busRead = 1'b0;
    v = busRdata;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [15:0] exp);
    logic [15:0] v;
    busRd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic gpioWrChk(input string tag, input logic [7:0] a, input logic [31:0] d);
    busWr(a, d);
    chk({tag, " R6 out"}, gpioOut, mOut);
    chk({tag, " R7 chg"}, gpioChg, mChg);
    @(negedge clk);
    chk({tag, " R7 chg one cycle"}, gpioChg, 16'h0);
  endtask

  task automatic setIn(input logic [15:0] v);
    @(negedge clk);
    gpioIn = v;
    for (int i = 0; i < 16; i++) if (v[i] != mIn[i]) mLvl[i] = v[i];
    mIn = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 out", gpioOut, 16'h0);
    chk("R1 chg", gpioChg, 16'h0);
    rdChk("R1 status", 8'h08, 16'h0002);
    rdChk("R1 mode", 8'h00, 16'h0);
    rdChk("R1 power", 8'h0C, 16'h0);
    rdChk("R1 dir", 8'h20, 16'h0);
    rdChk("R1 level", 8'h24, 16'h0);
    rdChk("R1 istat", 8'h1C, 16'h0);
  endtask

  task automatic t_plain();
    logic [7:0] offs [6] = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h18, 8'h1C};
    for (int i = 0; i < 6; i++) busWr(offs[i], 32'hBEEF_0000 | (32'h1111 * (i + 1)) ^ 32'h0100);
    for (int i = 0; i < 6; i++) begin
      logic [31:0] d;
      d = 32'hBEEF_0000 | (32'h1111 * (i + 1)) ^ 32'h0100;
      rdChk($sformatf("R2 reg %h", offs[i]), offs[i], d[15:0]);
    end
  endtask

  task automatic t_power();
    busWr(8'h0C, 32'h0000_0080); rdChk("R3 bit7 forces", 8'h0C, 16'h80C0);
    busWr(8'h0C, 32'h0000_1234); rdChk("R3 bit7 clear", 8'h0C, 16'h1234);
    busWr(8'h0C, 32'hFFFF_0003); rdChk("R3 R2 truncate", 8'h0C, 16'h0003);
    busWr(8'h0C, 32'h0100_0081); rdChk("R3 truncate then force", 8'h0C, 16'h80C1);
  endtask

  task automatic t_ignored();
    logic [15:0] modeVal;
    busRd(8'h00, modeVal);
    busWr(8'h08, 32'h0000_FFFF); rdChk("R4 status read-only", 8'h08, 16'h0002);
    busWr(8'h2C, 32'h0000_5555);
    busWr(8'h01, 32'h0000_AAAA);
    busWr(8'h40, 32'h0000_7777);
    rdChk("R4 mode untouched", 8'h00, modeVal);
    rdChk("R4 power untouched", 8'h0C, 16'h80C1);
    rdChk("R4 dir untouched", 8'h20, 16'h0);
    chk("R4 out untouched", gpioOut, 16'h0);
    rdChk("R4 read 0x2C", 8'h2C, 16'h0);
    rdChk("R4 read 0x01", 8'h01, 16'h0);
    rdChk("R4 read 0xFC", 8'hFC, 16'h0);
  endtask

  task automatic t_gpio();
    gpioWrChk("R5 level with dir 0", 8'h24, 32'h0000_FFFF);
    rdChk("R5 masked level", 8'h24, 16'h0000);
    gpioWrChk("R6 dir write", 8'h20, 32'h0000_00FF);
    gpioWrChk("R6 level 0x24", 8'h24, 32'h1234_A5A5);
    rdChk("R5 level", 8'h24, 16'h00A5);
    gpioWrChk("R6 level 0x28", 8'h28, 32'h0000_005A);
    rdChk("R5 read 0x28", 8'h28, 16'h005A);
    gpioWrChk("R6 dir narrows", 8'h20, 32'h0000_000F);
    rdChk("R5 read dir", 8'h20, 16'h000F);
    rdChk("R5 level kept", 8'h24, 16'h005A);
    gpioWrChk("R6 dir widens", 8'h20, 32'h0000_00FF);
  endtask

  task automatic t_input();
    setIn(16'h0100);
    chk("R8 out unmoved", gpioOut, mOut);
    chk("R8 no chg", gpioChg, 16'h0);
    rdChk("R8 level set", 8'h24, mLvl);
    setIn(16'h0108);
    setIn(16'h0100);
    rdChk("R8 level cleared", 8'h28, mLvl);
    chk("R8 out still", gpioOut, 16'h005A);
    gpioWrChk("R8 next dir write", 8'h20, 32'h0000_00FF);
    chk("R8 out follows", gpioOut, 16'h0052);
  endtask

  task automatic t_collide();
    setIn(16'h0101);
    rdChk("R8 bit0 up", 8'h24, mLvl);
    @(negedge clk);
    gpioIn = 16'h0100;
    busAddr = 8'h24; busWdata = 32'h0000_FFFF; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
    modelWrite(8'h24, 32'h0000_FFFF);
    mIn = 16'h0100;
    chk("R9 out after collide", gpioOut, 16'h00FF);
    rdChk("R9 write wins", 8'h24, 16'h00FF);
    gpioWrChk("R9 dir rewrite", 8'h20, 32'h0000_00FF);
  endtask

  task automatic t_rdata();
    logic [15:0] v;
    busRd(8'h08, v);
    chk("R10 valid next cycle", v, 16'h0002);
    busWr(8'h00, 32'h0000_4321);
    repeat (3) @(negedge clk);
    chk("R10 holds", busRdata, 16'h0002);
    rdChk("R10 new read", 8'h00, 16'h4321);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_power();
    t_ignored();
    t_gpio();
    t_input();
    t_collide();
    t_rdata();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule